// File: doc/BRIEF.md
# Ethernet Transmit Frame Assembler

This block turns a stream of 32-bit words, pulled one at a time from a transmit FIFO, into a complete Ethernet frame on a nibble-wide media-independent output. Each frame starts with a preamble and a start delimiter. The payload bytes follow. Frames shorter than the minimum are zero-padded, and the frame ends with the inverted CRC-32 of everything after the delimiter. When a frame's no-CRC flag is set, the block sends only the payload, with no pad and no CRC. After every frame the output stays idle for an interframe gap before the next frame may start.

The source offers a word with `in_valid`, marks the final word of a frame with `in_last`, and on that word gives the number of valid bytes in `in_bytes`. The block takes a word in each cycle where `in_ready` is high. Within a frame it needs each word the moment it asks for it, because the line cannot be stalled. One output nibble is sent per clock.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held and after it is released with no word offered, `tx_en` is low and `in_ready` is low.
- R2: Every frame starts with seven 0x55 bytes and then one 0xD5 byte. Each byte is sent as two nibbles on `txd`, bits 3:0 first and bits 7:4 second, one nibble per clock while `tx_en` is high.
- R3: Payload bytes are sent in word order. Within a word, bits 7:0 go first and bits 31:24 go last. A word without `in_last` contributes four bytes. The final word contributes `in_bytes` bytes, where `in_bytes` is coded 1, 2, 3 or 4 and counts from bits 7:0 upward.
- R4: When the no-CRC flag is clear and the payload is shorter than 60 bytes, 0x00 bytes follow the payload until 60 bytes have been sent after the delimiter. Payloads of 60 bytes or more get no pad.
- R5: When the no-CRC flag is clear, four check bytes end the frame. The CRC is the reflected CRC-32 (polynomial 0xEDB88320), starts from all ones, and covers the payload and pad. It is inverted and sent least significant byte first.
- R6: When the no-CRC flag is set, `tx_en` falls right after the last payload byte, with no pad and no CRC.
- R7: The no-CRC flag is taken from `in_nocrc` on the first word of a frame only. Its value on any later word of the same frame has no effect on the output.
- R8: Between two frames `tx_en` stays low for at least 24 clocks. When the next frame is already waiting, the gap is at most 25 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A FIFO word is offered |
| in_ready | output | 1 | The offered word is taken at this clock edge |
| in_data | input | 32 | FIFO word, first byte in bits 7:0 |
| in_last | input | 1 | The offered word is the last of its frame |
| in_bytes | input | 3 | Valid bytes in the last word, 1 to 4 |
| in_nocrc | input | 1 | No-CRC flag, used on the first word of a frame |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |

## Verification
The bench builds the block with its default parameters: seven preamble bytes, a 64-byte minimum frame and a 24-clock gap. With these values the pad threshold at 59, 60 and 61 payload bytes and the exact gap window of 24 to 25 clocks can be checked against the figures in the requirements. Payload lengths from 1 to 100 bytes, mixed with directed short and no-CRC frames, place the final word at every byte count from 1 to 4. Frames are sent both back-to-back and after random idle stretches. The no-CRC value on later words is randomised or forced high, so any leak of that value into the output would show.

// File: rtl/eth_tx_pkg.sv
`timescale 1ns/1ps
package eth_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_DATA,
      ST_PAD,
      ST_FCS,
      ST_GAP
   } tx_state_e;

   localparam logic [7:0]  PRE_BYTE     = 8'h55;
   localparam logic [7:0]  SFD_BYTE     = 8'hD5;
   localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;

   // Advance a reflected CRC-32 by one byte, one input bit at a time.
   function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REF;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/eth_tx_crc32.sv
`timescale 1ns/1ps
module eth_tx_crc32
   import eth_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        init,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [31:0] crc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= '1;
      else if (init) crc <= '1;
      else if (en)   crc <= crc_step(crc, din);
   end

endmodule

// File: rtl/eth_tx_gap_timer.sv
`timescale 1ns/1ps
module eth_tx_gap_timer #(
   parameter int unsigned GAP_NIB = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   localparam int unsigned CW = (GAP_NIB < 2) ? 1 : $clog2(GAP_NIB);

   if (GAP_NIB < 1) begin : g_bad_gap
      $error("GAP_NIB must be at least 1");
   end

   if (GAP_NIB == 1) begin : g_single
      assign done = run;
   end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    cnt <= '0;
         else if (!run) cnt <= '0;
         else if (!done) cnt <= cnt + 1'b1;
      end
      assign done = run && (cnt == CW'(GAP_NIB - 1));

      // R8
      gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(run) |-> cnt == '0);
   end

endmodule

// File: rtl/eth_tx_word_lane.sv
`timescale 1ns/1ps
module eth_tx_word_lane #(
   parameter int unsigned LANES = 4
) (
   input  logic [8*LANES-1:0]         word,
   input  logic [$clog2(LANES)-1:0]   lane,
   input  logic [$clog2(LANES):0]     nbytes,
   output logic [7:0]                 byte_o,
   output logic                       at_end
);

   localparam int unsigned LW = $clog2(LANES);

   if (LANES < 2 || (1 << LW) != LANES) begin : g_bad_lanes
      $error("LANES must be a power of two, at least 2");
   end

   logic [7:0] lane_b [LANES];
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_b[g] = word[8*g +: 8];
   end

   assign byte_o = lane_b[lane];
   assign at_end = ({1'b0, lane} + 1'b1) == nbytes;

endmodule

// File: rtl/eth_tx_framer.sv
`timescale 1ns/1ps
module eth_tx_framer
   import eth_tx_pkg::*;
#(
   parameter int unsigned PRE_BYTES = 7,
   parameter int unsigned MIN_FRAME = 64,
   parameter int unsigned GAP_NIB   = 24,
   parameter int unsigned LEN_W     = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [31:0] in_data,
   input  logic        in_last,
   input  logic [2:0]  in_bytes,
   input  logic        in_nocrc,
   output logic [3:0]  txd,
   output logic        tx_en
);

   localparam int unsigned PAD_TO = MIN_FRAME - 4;
   localparam int unsigned IDX_W  = 3;
   localparam logic [IDX_W-1:0] SFD_IDX  = IDX_W'(PRE_BYTES);
   localparam logic [LEN_W-1:0] PAD_LAST = LEN_W'(PAD_TO - 1);
   localparam logic [LEN_W-1:0] PAD_MIN  = LEN_W'(PAD_TO);

   if (PRE_BYTES < 1 || PRE_BYTES > 7) begin : g_bad_pre
      $error("PRE_BYTES must lie in 1..7");
   end
   if (MIN_FRAME < 8 || PAD_TO >= (1 << LEN_W)) begin : g_bad_min
      $error("MIN_FRAME out of range for LEN_W");
   end

   tx_state_e        st;
   logic             phase;
   logic [IDX_W-1:0] idx;
   logic [1:0]       lane;
   logic [2:0]       nb;
   logic             wlast;
   logic [31:0]      wreg;
   logic [LEN_W-1:0] cnt;
   logic             nocrc_q;

   logic [7:0]  word_byte;
   logic        lane_end;
   logic [7:0]  cur_byte;
   logic [31:0] crc_q;
   logic        crc_en;
   logic        gap_done;
   logic        take;

   eth_tx_word_lane #(.LANES(4)) u_lane (
      .word   (wreg),
      .lane   (lane),
      .nbytes (nb),
      .byte_o (word_byte),
      .at_end (lane_end)
   );

   assign crc_en = phase && (st == ST_DATA || st == ST_PAD);

   eth_tx_crc32 u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .init  (st == ST_IDLE),
      .en    (crc_en),
      .din   (cur_byte),
      .crc   (crc_q)
   );

   eth_tx_gap_timer #(.GAP_NIB(GAP_NIB)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st == ST_GAP),
      .done  (gap_done)
   );

   always_comb begin
      case (st)
         ST_PRE:  cur_byte = (idx == SFD_IDX) ? SFD_BYTE : PRE_BYTE;
         ST_DATA: cur_byte = word_byte;
         ST_FCS:  cur_byte = ~crc_q[8*idx[1:0] +: 8];
         default: cur_byte = 8'h00;
      endcase
   end

   assign tx_en = (st == ST_PRE) || (st == ST_DATA) || (st == ST_PAD) || (st == ST_FCS);
   assign txd   = !tx_en ? 4'h0 : (phase ? cur_byte[7:4] : cur_byte[3:0]);

   assign take = phase && (((st == ST_PRE) && (idx == SFD_IDX)) ||
                           ((st == ST_DATA) && lane_end && !wlast));
   assign in_ready = take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         phase   <= 1'b0;
         idx     <= '0;
         lane    <= '0;
         nb      <= 3'd4;
         wlast   <= 1'b0;
         wreg    <= '0;
         cnt     <= '0;
         nocrc_q <= 1'b0;
      end else begin
         if (tx_en) phase <= ~phase;
         if (take) begin
            wreg  <= in_data;
            nb    <= in_last ? in_bytes : 3'd4;
            wlast <= in_last;
            lane  <= '0;
         end
         case (st)
            ST_IDLE: if (in_valid) begin
               st      <= ST_PRE;
               phase   <= 1'b0;
               idx     <= '0;
               cnt     <= '0;
               nocrc_q <= in_nocrc;
            end
            ST_PRE: if (phase) begin
               if (idx == SFD_IDX) st <= ST_DATA;
               else                idx <= idx + 1'b1;
            end
            ST_DATA: if (phase) begin
               cnt <= cnt + 1'b1;
               if (!lane_end) begin
                  lane <= lane + 1'b1;
               end else if (wlast) begin
                  idx <= '0;
                  if (nocrc_q)              st <= ST_GAP;
                  else if (cnt < PAD_LAST)  st <= ST_PAD;
                  else                      st <= ST_FCS;
               end
            end
            ST_PAD: if (phase) begin
               cnt <= cnt + 1'b1;
               if (cnt >= PAD_LAST) st <= ST_FCS;
            end
            ST_FCS: if (phase) begin
               if (idx == IDX_W'(3)) st <= ST_GAP;
               else                  idx <= idx + 1'b1;
            end
            ST_GAP: if (gap_done) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R2
   sfd_before_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DATA && $past(st) != ST_DATA) |-> ($past(st) == ST_PRE && $past(idx) == SFD_IDX));

   // R3
   take_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (phase && tx_en));

   // R4
   pad_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FCS && $past(st) != ST_FCS) |-> cnt >= PAD_MIN);

   // R6
   nocrc_no_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nocrc_q |-> (st != ST_PAD && st != ST_FCS));

   // R7
   nocrc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(nocrc_q));

   // R8
   gap_follows_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_en) |-> st == ST_GAP);

endmodule

// File: tb/sim_eth_tx_framer.sv
`timescale 1ns/1ps
module sim_eth_tx_framer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        in_last = 1'b0;
   logic [2:0]  in_bytes = 3'd4;
   logic        in_nocrc = 1'b0;
   logic [3:0]  txd;
   logic        tx_en;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   eth_tx_framer u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .in_bytes(in_bytes),
      .in_nocrc(in_nocrc), .txd(txd), .tx_en(tx_en)
   );

   logic [7:0] exp_b[$];
   string      exp_t[$];
   int         exp_len[$];
   string      exp_ft[$];
   bit         exp_b2b[$];

   function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r;
      r = c ^ {24'h0, d};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   // ---------------- output monitor ----------------
   bit         in_frame = 1'b0;
   bit         seen_prev = 1'b0;
   bit         nib_hi = 1'b0;
   logic [3:0] lo_nib;
   logic [7:0] got[$];
   int         gap = 0;
   int         frame_no = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_en) begin
            if (!in_frame) begin
               bit b2b;
               in_frame = 1'b1;
               nib_hi = 1'b0;
               got.delete();
               b2b = (exp_b2b.size() != 0) ? exp_b2b.pop_front() : 1'b0;
               if (seen_prev) begin
                  check(gap >= 24, "R8", "interframe gap minimum", gap, 24);
                  if (b2b) check(gap <= 25, "R8", "back-to-back gap maximum", gap, 25);
               end
            end
            if (!nib_hi) lo_nib = txd;
            else         got.push_back({txd, lo_nib});
            nib_hi = ~nib_hi;
         end else if (in_frame) begin
            int l;
            string ft;
            in_frame = 1'b0;
            seen_prev = 1'b1;
            gap = 1;
            l  = (exp_len.size() != 0) ? exp_len.pop_front() : -1;
            ft = (exp_ft.size() != 0) ? exp_ft.pop_front() : "R3";
            check(got.size() == l, ft, $sformatf("frame %0d byte count", frame_no), got.size(), l);
            for (int i = 0; i < l; i++) begin
               logic [7:0] e;
               string t;
               e = exp_b.pop_front();
               t = exp_t.pop_front();
               if (i < got.size())
                  check(got[i] === e, t, $sformatf("frame %0d (%s) byte %0d", frame_no, ft, i), got[i], e);
            end
            frame_no++;
         end else begin
            gap++;
         end
      end
   end

   // ---------------- stimulus ----------------
   logic [7:0] pl [0:127];

   task automatic send_frame(input int len, input bit nc, input bit later_nc_hi,
                             input int idle_before, input bit first, input string ft);
      int nw, padded;
      logic [31:0] c;
      for (int i = 0; i < len; i++) pl[i] = 8'($urandom);
      // expected frame
      padded = (!nc && len < 60) ? 60 : len;
      for (int i = 0; i < 7; i++) begin exp_b.push_back(8'h55); exp_t.push_back("R2"); end
      exp_b.push_back(8'hD5); exp_t.push_back("R2");
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < padded; i++) begin
         logic [7:0] bv;
         bv = (i < len) ? pl[i] : 8'h00;
         c = ref_crc(c, bv);
         exp_b.push_back(bv);
         exp_t.push_back((i < len) ? "R3" : "R4");
      end
      if (!nc) begin
         c = ~c;
         for (int i = 0; i < 4; i++) begin exp_b.push_back(c[8*i +: 8]); exp_t.push_back("R5"); end
      end
      exp_len.push_back(8 + padded + (nc ? 0 : 4));
      exp_ft.push_back(ft);
      exp_b2b.push_back(!first && idle_before == 0);
      // idle stretch
      if (idle_before > 0) begin
         in_valid = 1'b0;
         for (int i = 0; i < idle_before; i++) @(negedge clk);
      end
      nw = (len + 3) / 4;
      for (int w = 0; w < nw; w++) begin
         logic [31:0] d;
         for (int k = 0; k < 4; k++) d[8*k +: 8] = (4*w + k < len) ? pl[4*w + k] : 8'h00;
         in_valid = 1'b1;
         in_data  = d;
         in_last  = (w == nw - 1);
         in_bytes = (w == nw - 1) ? 3'(len - 4*w) : 3'd4;
         in_nocrc = (w == 0) ? nc : (later_nc_hi ? 1'b1 : 1'($urandom));
         forever begin
            if (in_ready) begin
               @(posedge clk);
               @(negedge clk);
               break;
            end
            @(negedge clk);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(tx_en == 1'b0, "R1", "tx_en in reset", tx_en, 0);
      check(in_ready == 1'b0, "R1", "in_ready in reset", in_ready, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(tx_en == 1'b0, "R1", "tx_en idle after reset", tx_en, 0);
      check(in_ready == 1'b0, "R1", "in_ready idle after reset", in_ready, 0);

      send_frame(1,  1'b0, 1'b0, 0, 1'b1, "R4");
      send_frame(59, 1'b0, 1'b0, 0, 1'b0, "R4");
      send_frame(60, 1'b0, 1'b0, 0, 1'b0, "R5");
      send_frame(61, 1'b0, 1'b0, 4, 1'b0, "R3");
      send_frame(3,  1'b1, 1'b0, 0, 1'b0, "R6");
      send_frame(66, 1'b1, 1'b0, 2, 1'b0, "R6");
      send_frame(10, 1'b0, 1'b1, 0, 1'b0, "R7");
      send_frame(9,  1'b1, 1'b0, 0, 1'b0, "R7");
      send_frame(2,  1'b0, 1'b1, 7, 1'b0, "R7");
      for (int f = 0; f < 24; f++) begin
         int len, idle;
         bit nc;
         len  = 1 + int'($urandom % 100);
         nc   = ($urandom % 5) == 0;
         idle = (($urandom % 2) == 0) ? 0 : int'($urandom % 11);
         send_frame(len, nc, 1'b0, idle, 1'b0, nc ? "R6" : "R3");
      end
      @(negedge clk);
      in_valid = 1'b0;
      while (exp_len.size() != 0 || tx_en) @(negedge clk);
      repeat (30) @(negedge clk);
      check(tx_en == 1'b0, "R8", "line idle at end", tx_en, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         vectors++;
         fails++;
         $display("FAIL R3 watchdog expired: actual %0d frames expected %0d frames", frame_no, 33);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule